// File: doc/BRIEF.md
# Two-Bank Multiplexed Latching Bus Exchanger

This block couples one host-side data port (A) with two bank-side ports, an even bank (B1) and an odd bank (B2). In the host-to-bank direction it can split one shared address/data stream across the two banks. Each bank has its own level-sensitive holding latch fed from A, and each bank has its own output enable. In the bank-to-host direction each bank has its own holding latch. A select input decides which of the two bank latches drives A.

Every pin is modelled as a pad with split signals. The outside world presents a value and a drive flag, and the pad reports the resolved pin level and whether the block itself drives it. The block's own drive takes priority over the external driver. When neither side drives a pin, a per-bit keeper shows the last level that was driven onto it. All latches sample resolved pin levels. An active-low asynchronous reset clears the four path latches and the three keepers to zero, which gives the bench a known starting point.

Top module: `bank_mux_latch`

## Requirements
- R1: While `rst_n` is low, all four path latches and all keepers read zero. After `rst_n` rises with every latch enable low, an enabled port drives zero.
- R2: While `en_a_b1` is high, `b1_oe_n` is low and A is driven from outside, `b1_pin` equals the A pin level and follows every change of it.
- R3: When a latch enable falls, that latch keeps the value it had just before the edge. Later changes on its input do not appear on its output until the enable rises again.
- R4: The A-to-B2 latch, opened by `en_a_b2`, behaves like the A-to-B1 latch. It does not disturb the A-to-B1 latch, and the A-to-B1 latch does not disturb it.
- R5: With `a_oe_n` low, `a_pin` shows the B1-to-A latch when `pick_b1` is 1 and the B2-to-A latch when `pick_b1` is 0.
- R6: The B1-to-A and B2-to-A latches, opened by `en_b1_a` and `en_b2_a`, are transparent to their bank pin while open and hold after the falling edge.
- R7: Each output enable is active low. While a port's enable is high, its `*_drv` output is 0 and its pin shows the external value whenever the external driver is on.
- R8: The two bank enables act independently. Either bank alone can be driven, as can both or neither.
- R9: When neither the block nor the outside drives a pin, the pin keeps the last externally driven level. A change on the external data while the external driver is off has no effect on the pin.
- R10: When the block stops driving a pin and no external driver is on, the pin keeps the last level the block drove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of latches and keepers |
| a_ext_d | input | W | Value presented on the A pins by the host |
| a_ext_en | input | 1 | Host drives the A pins |
| a_pin | output | W | Resolved A pin level |
| a_drv | output | 1 | Block drives the A pins |
| b1_ext_d | input | W | Value presented on the B1 pins by the even bank |
| b1_ext_en | input | 1 | Even bank drives the B1 pins |
| b1_pin | output | W | Resolved B1 pin level |
| b1_drv | output | 1 | Block drives the B1 pins |
| b2_ext_d | input | W | Value presented on the B2 pins by the odd bank |
| b2_ext_en | input | 1 | Odd bank drives the B2 pins |
| b2_pin | output | W | Resolved B2 pin level |
| b2_drv | output | 1 | Block drives the B2 pins |
| en_a_b1 | input | 1 | Opens the A-to-B1 latch while high |
| en_a_b2 | input | 1 | Opens the A-to-B2 latch while high |
| en_b1_a | input | 1 | Opens the B1-to-A latch while high |
| en_b2_a | input | 1 | Opens the B2-to-A latch while high |
| pick_b1 | input | 1 | 1 selects the B1-to-A latch toward A, 0 selects B2-to-A |
| a_oe_n | input | 1 | Active-low output enable of A |
| b1_oe_n | input | 1 | Active-low output enable of B1 |
| b2_oe_n | input | 1 | Active-low output enable of B2 |

## Verification
The bench builds the block with its default width of 12 bits. At that width, patterns such as alternating nibbles, all zeros and all ones pass through every path and make a stuck or swapped bit visible. Because the width is exactly three nibbles, each path can be loaded with a distinct value. Selection, holding and keeper retention can then be told apart at the pins.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    typedef enum int unsigned {
        PAD_A  = 0,
        PAD_B1 = 1,
        PAD_B2 = 2
    } pad_e;

    typedef enum int unsigned {
        PATH_A_B1 = 0,
        PATH_A_B2 = 1,
        PATH_B1_A = 2,
        PATH_B2_A = 3
    } path_e;

    localparam int unsigned NUM_PADS  = 3;
    localparam int unsigned NUM_PATHS = 4;
endpackage

// File: rtl/bmx_level_latch.sv
// Level-sensitive holding latch: transparent while open_i is high.
module bmx_level_latch #(
    parameter int unsigned W = 12
) (
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_latch begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (open_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/bmx_keeper_pad.sv
// Pad model: own drive wins over the external driver; when no one drives,
// a keeper shows the last level that was driven onto the pin.
module bmx_keeper_pad #(
    parameter int unsigned W = 12
) (
    input  logic         rst_n,
    input  logic         own_en_i,
    input  logic [W-1:0] own_d_i,
    input  logic         ext_en_i,
    input  logic [W-1:0] ext_d_i,
    output logic [W-1:0] pin_o
);
    logic         driven;
    logic [W-1:0] drive_val;
    logic [W-1:0] held;

    assign driven    = own_en_i | ext_en_i;
    assign drive_val = own_en_i ? own_d_i : ext_d_i;

    always_latch begin
        if (!rst_n) begin
            held <= '0;
        end else if (driven) begin
            held <= drive_val;
        end
    end

    assign pin_o = driven ? drive_val : held;
endmodule

// File: rtl/bank_mux_latch.sv
module bank_mux_latch #(
    parameter int unsigned W = 12
) (
    input  logic         rst_n,
    input  logic [W-1:0] a_ext_d,
    input  logic         a_ext_en,
    output logic [W-1:0] a_pin,
    output logic         a_drv,
    input  logic [W-1:0] b1_ext_d,
    input  logic         b1_ext_en,
    output logic [W-1:0] b1_pin,
    output logic         b1_drv,
    input  logic [W-1:0] b2_ext_d,
    input  logic         b2_ext_en,
    output logic [W-1:0] b2_pin,
    output logic         b2_drv,
    input  logic         en_a_b1,
    input  logic         en_a_b2,
    input  logic         en_b1_a,
    input  logic         en_b2_a,
    input  logic         pick_b1,
    input  logic         a_oe_n,
    input  logic         b1_oe_n,
    input  logic         b2_oe_n
);
    import bmx_pkg::*;

    logic         pad_own_en [NUM_PADS];
    logic [W-1:0] pad_own_d  [NUM_PADS];
    logic         pad_ext_en [NUM_PADS];
    logic [W-1:0] pad_ext_d  [NUM_PADS];
    logic [W-1:0] pad_pin    [NUM_PADS];

    logic         lat_open [NUM_PATHS];
    logic [W-1:0] lat_d    [NUM_PATHS];
    logic [W-1:0] lat_q    [NUM_PATHS];

    logic [W-1:0] a_side_val;

    // Latch wiring: host pin feeds bank-bound latches, bank pins feed host-bound ones.
    assign lat_open[PATH_A_B1] = en_a_b1;
    assign lat_open[PATH_A_B2] = en_a_b2;
    assign lat_open[PATH_B1_A] = en_b1_a;
    assign lat_open[PATH_B2_A] = en_b2_a;
    assign lat_d[PATH_A_B1]    = pad_pin[PAD_A];
    assign lat_d[PATH_A_B2]    = pad_pin[PAD_A];
    assign lat_d[PATH_B1_A]    = pad_pin[PAD_B1];
    assign lat_d[PATH_B2_A]    = pad_pin[PAD_B2];

    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
        bmx_level_latch #(.W(W)) u_lat (
            .rst_n  (rst_n),
            .open_i (lat_open[i]),
            .d_i    (lat_d[i]),
            .q_o    (lat_q[i])
        );
    end

    // Bank select toward the host.
    assign a_side_val = pick_b1 ? lat_q[PATH_B1_A] : lat_q[PATH_B2_A];

    assign pad_own_en[PAD_A]  = ~a_oe_n;
    assign pad_own_en[PAD_B1] = ~b1_oe_n;
    assign pad_own_en[PAD_B2] = ~b2_oe_n;
    assign pad_own_d[PAD_A]   = a_side_val;
    assign pad_own_d[PAD_B1]  = lat_q[PATH_A_B1];
    assign pad_own_d[PAD_B2]  = lat_q[PATH_A_B2];
    assign pad_ext_en[PAD_A]  = a_ext_en;
    assign pad_ext_en[PAD_B1] = b1_ext_en;
    assign pad_ext_en[PAD_B2] = b2_ext_en;
    assign pad_ext_d[PAD_A]   = a_ext_d;
    assign pad_ext_d[PAD_B1]  = b1_ext_d;
    assign pad_ext_d[PAD_B2]  = b2_ext_d;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        bmx_keeper_pad #(.W(W)) u_pad (
            .rst_n    (rst_n),
            .own_en_i (pad_own_en[p]),
            .own_d_i  (pad_own_d[p]),
            .ext_en_i (pad_ext_en[p]),
            .ext_d_i  (pad_ext_d[p]),
            .pin_o    (pad_pin[p])
        );
    end

    assign a_pin  = pad_pin[PAD_A];
    assign b1_pin = pad_pin[PAD_B1];
    assign b2_pin = pad_pin[PAD_B2];
    assign a_drv  = pad_own_en[PAD_A];
    assign b1_drv = pad_own_en[PAD_B1];
    assign b2_drv = pad_own_en[PAD_B2];
endmodule

// File: rtl/bank_mux_latch_chk.sv
module bank_mux_latch_chk #(
    parameter int unsigned W = 12
) (
    input logic         rst_n,
    input logic [W-1:0] a_ext_d,
    input logic         a_ext_en,
    input logic [W-1:0] a_pin,
    input logic [W-1:0] b1_ext_d,
    input logic         b1_ext_en,
    input logic [W-1:0] b1_pin,
    input logic [W-1:0] b2_ext_d,
    input logic         b2_ext_en,
    input logic [W-1:0] b2_pin,
    input logic         en_a_b1,
    input logic         en_a_b2,
    input logic         en_b1_a,
    input logic         en_b2_a,
    input logic         pick_b1,
    input logic         a_oe_n,
    input logic         b1_oe_n,
    input logic         b2_oe_n
);
    // At the closing edge of A-to-B1, an enabled B1 carries the host-driven A value.
    p_close_ab1_r2: assert property (@(negedge en_a_b1) disable iff (!rst_n)
        (!b1_oe_n && a_oe_n && a_ext_en) |-> (b1_pin == a_ext_d));

    p_close_ab2_r4: assert property (@(negedge en_a_b2) disable iff (!rst_n)
        (!b2_oe_n && a_oe_n && a_ext_en) |-> (b2_pin == a_ext_d));

    p_pick_b1_r5: assert property (@(negedge en_b1_a) disable iff (!rst_n)
        (pick_b1 && !a_oe_n && b1_oe_n && b1_ext_en) |-> (a_pin == b1_ext_d));

    p_pick_b2_r5: assert property (@(negedge en_b2_a) disable iff (!rst_n)
        (!pick_b1 && !a_oe_n && b2_oe_n && b2_ext_en) |-> (a_pin == b2_ext_d));

    p_ext_visible_r7: assert property (@(negedge a_ext_en) disable iff (!rst_n)
        a_oe_n |-> (a_pin == a_ext_d));
endmodule

bind bank_mux_latch bank_mux_latch_chk #(.W(W)) u_chk (.*);

// File: tb/bank_mux_latch_tb.sv
module bank_mux_latch_tb;
    localparam int unsigned W = 12;
    localparam int unsigned WATCHDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_ext_d, b1_ext_d, b2_ext_d;
    logic         a_ext_en, b1_ext_en, b2_ext_en;
    logic [W-1:0] a_pin, b1_pin, b2_pin;
    logic         a_drv, b1_drv, b2_drv;
    logic         en_a_b1, en_a_b2, en_b1_a, en_b2_a;
    logic         pick_b1, a_oe_n, b1_oe_n, b2_oe_n;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        int           port;
        logic [W-1:0] val;
        string        tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #4 clk = ~clk;

    bank_mux_latch #(.W(W)) u_dut (
        .rst_n(rst_n),
        .a_ext_d(a_ext_d), .a_ext_en(a_ext_en), .a_pin(a_pin), .a_drv(a_drv),
        .b1_ext_d(b1_ext_d), .b1_ext_en(b1_ext_en), .b1_pin(b1_pin), .b1_drv(b1_drv),
        .b2_ext_d(b2_ext_d), .b2_ext_en(b2_ext_en), .b2_pin(b2_pin), .b2_drv(b2_drv),
        .en_a_b1(en_a_b1), .en_a_b2(en_a_b2), .en_b1_a(en_b1_a), .en_b2_a(en_b2_a),
        .pick_b1(pick_b1), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n)
    );

    // port codes: 0 a_pin, 1 b1_pin, 2 b2_pin, 3 a_drv, 4 b1_drv, 5 b2_drv
    task automatic expect_val(input int port, input logic [W-1:0] v, input string tag);
        sb_item_t it;
        it.port = port;
        it.val  = v;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
    endtask

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin : mon
        sb_item_t     it;
        logic [W-1:0] got;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.port)
                0: got = a_pin;
                1: got = b1_pin;
                2: got = b2_pin;
                3: got = {{(W-1){1'b0}}, a_drv};
                4: got = {{(W-1){1'b0}}, b1_drv};
                default: got = {{(W-1){1'b0}}, b2_drv};
            endcase
            total++;
            if (got !== it.val) begin
                bad++;
                $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.port, got, it.val);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0;
        a_ext_d = '0; b1_ext_d = '0; b2_ext_d = '0;
        a_ext_en = 1'b0; b1_ext_en = 1'b0; b2_ext_en = 1'b0;
        en_a_b1 = 1'b0; en_a_b2 = 1'b0; en_b1_a = 1'b0; en_b2_a = 1'b0;
        pick_b1 = 1'b0;
        a_oe_n = 1'b1; b1_oe_n = 1'b1; b2_oe_n = 1'b1;

        // R1: reset state seen through enabled outputs
        step();
        a_oe_n = 1'b0; b1_oe_n = 1'b0; b2_oe_n = 1'b0;
        expect_val(0, 12'h000, "R1 a in reset");
        expect_val(1, 12'h000, "R1 b1 in reset");
        expect_val(2, 12'h000, "R1 b2 in reset");
        expect_val(3, 12'h001, "R1 a_drv");
        step();
        rst_n = 1'b1;
        expect_val(1, 12'h000, "R1 b1 after reset");
        expect_val(0, 12'h000, "R1 a after reset");
        step();
        a_oe_n = 1'b1; b1_oe_n = 1'b1; b2_oe_n = 1'b1;

        // R2: A to B1 transparent
        step();
        a_ext_en = 1'b1; a_ext_d = 12'hA5C; b1_oe_n = 1'b0; en_a_b1 = 1'b1;
        expect_val(1, 12'hA5C, "R2 b1 follows a");
        step();
        a_ext_d = 12'h3F1;
        expect_val(1, 12'h3F1, "R2 b1 follows change");

        // R3: hold after closing edge
        step();
        en_a_b1 = 1'b0;
        expect_val(1, 12'h3F1, "R3 b1 at close");
        step();
        a_ext_d = 12'h777;
        expect_val(1, 12'h3F1, "R3 b1 holds");

        // R4 and R8: second bank path, independent
        step();
        b2_oe_n = 1'b0; en_a_b2 = 1'b1;
        expect_val(2, 12'h777, "R4 b2 follows a");
        expect_val(1, 12'h3F1, "R4 b1 undisturbed");
        step();
        en_a_b2 = 1'b0;
        step();
        a_ext_d = 12'h123;
        expect_val(2, 12'h777, "R4 b2 holds");
        expect_val(1, 12'h3F1, "R4 b1 still held");
        step();
        b1_oe_n = 1'b1;
        expect_val(4, 12'h000, "R8 b1 off");
        expect_val(5, 12'h001, "R8 b2 on");
        expect_val(2, 12'h777, "R8 b2 still driven");
        expect_val(1, 12'h3F1, "R10 b1 keeps own drive");

        // R7: disabled port shows external value
        step();
        b2_oe_n = 1'b1;
        b1_ext_en = 1'b1; b1_ext_d = 12'h0F0;
        expect_val(1, 12'h0F0, "R7 b1 shows external");
        expect_val(4, 12'h000, "R7 b1_drv low");
        expect_val(5, 12'h000, "R8 neither bank driven");

        // R6 and R5: B1 to A
        step();
        en_b1_a = 1'b1; pick_b1 = 1'b1;
        step();
        a_ext_en = 1'b0;
        step();
        a_oe_n = 1'b0;
        expect_val(0, 12'h0F0, "R6 a from b1");
        expect_val(3, 12'h001, "R7 a_drv on");
        step();
        b1_ext_d = 12'hABC;
        expect_val(0, 12'hABC, "R6 b1 latch transparent");
        step();
        en_b1_a = 1'b0;
        step();
        b1_ext_d = 12'h001;
        expect_val(0, 12'hABC, "R6 b1 latch holds");
        expect_val(1, 12'h001, "R7 b1 pin external");

        // R5: B2 path and selection
        step();
        b2_ext_en = 1'b1; b2_ext_d = 12'h5A5; pick_b1 = 1'b0; en_b2_a = 1'b1;
        expect_val(0, 12'h5A5, "R5 a from b2");
        step();
        en_b2_a = 1'b0;
        step();
        b2_ext_d = 12'h111;
        expect_val(0, 12'h5A5, "R6 b2 latch holds");
        step();
        pick_b1 = 1'b1;
        expect_val(0, 12'hABC, "R5 pick b1");
        step();
        pick_b1 = 1'b0;
        expect_val(0, 12'h5A5, "R5 pick b2");

        // R9: keeper after external release
        step();
        b2_ext_en = 1'b0;
        expect_val(2, 12'h111, "R9 b2 keeps external");
        step();
        b2_ext_d = 12'hFFF;
        expect_val(2, 12'h111, "R9 undriven data ignored");

        // R10: keeper after own drive stops
        step();
        a_oe_n = 1'b1;
        expect_val(0, 12'h5A5, "R10 a keeps own drive");
        expect_val(3, 12'h000, "R7 a_drv off");
        step();
        a_ext_en = 1'b1; a_ext_d = 12'h000;
        expect_val(0, 12'h000, "R7 a shows external");
        step();
        a_ext_en = 1'b0;
        expect_val(0, 12'h000, "R9 a keeps zero");
        step();
        a_ext_en = 1'b1; a_ext_d = 12'hFFF;
        step();
        a_ext_en = 1'b0;
        expect_val(0, 12'hFFF, "R9 a keeps ones");

        // R1: reset mid-run clears the path latches
        step();
        b1_ext_en = 1'b0;
        rst_n = 1'b0;
        step();
        b1_oe_n = 1'b0;
        expect_val(1, 12'h000, "R1 b1 cleared");
        step();
        rst_n = 1'b1;
        expect_val(1, 12'h000, "R1 b1 zero after reset");
        step();
        step();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule